// File: doc/BRIEF.md
# Multi-Channel Serial Command Port Master

This block lets a host drive up to four tone encoder/decoder devices that share one serial clock line and one data line in each direction, each device with its own active-low select. The host fills in a channel/control register and up to two parameter bytes. It then writes a command code, and the block performs one complete serial transaction on its own. While the transaction runs, a busy flag is readable. The command code alone decides the transaction's shape: a command byte alone, a command byte plus one written byte, a command byte plus two written bytes, or a command byte followed by one byte read back from the device.

Read results are kept per channel in a live status store. The host sees them through a freeze window. While the freeze bit of the control register is set, host reads of addresses 0 to 3 return a snapshot of the per-channel status bytes instead of the configuration registers. Completed reads keep updating the live store but do not disturb the snapshot until the freeze bit is cleared. All bit timing comes from a parameter giving the half-period of the serial clock in system clock cycles.

Top module: `tone_ser_master`

## Requirements
- R1: Output `csN[ch]` is the active-low select of channel ch. At most one select is low at any time. All selects are high in reset and whenever no transaction runs.
- R2: The target channel is the 7-bit value {ctl[7:3], ctl[1:0]} of the control register (address 0). A command write when that value is 4 or more is ignored: no select falls and busy stays 0.
- R3: Command classes: code 0x01 sends the command byte only. Codes 0x80–0x87 send one parameter byte (address 1). Codes 0x88–0x8B send two parameter bytes (address 1, then address 2). Codes 0x8C–0x8F read one byte.
- R4: `sclk` idles high. `sdo` is high and held for two half-periods before a select falls.
- R5: Every byte goes out most significant bit first. A written bit is placed on `sdo` while `sclk` is high, then `sclk` goes low for one half-period and rises to latch it.
- R6: For a read bit, `sclk` goes low for one half-period and then high. `sdi` is sampled at the end of that high half-period and shifted in from the least significant end. `sdo` stays high during the read byte.
- R7: The high time between bits is one half-period and between bytes two half-periods. The select rises two half-periods after the last bit. A transaction of n bytes therefore holds its select low for 16n + (n−1) + 2 half-periods.
- R8: Writing address 3 with a valid code starts a transaction. Address 0xC bit 0 reads 1 from the next cycle until the transaction ends. With freeze clear, addresses 0–3 read back the control register, both parameter registers and the last accepted code.
- R9: A write to address 3 while busy is dropped: no extra transaction occurs, and the code read back at address 3 is unchanged.
- R10: The byte from a read command is stored for its channel when the select rises. While control bit 2 is set, reading address ch (0–3) returns the snapshot for channel ch, which later reads do not change until bit 2 is cleared.
- R11: A command code outside the R3 classes is a no-operation: no select falls, busy stays 0, and the code at address 3 is unchanged.
- R12: The select used is the one latched when the command is accepted, and it stays steady for the whole transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostAddr | input | 4 | Host register address |
| hostWr | input | 1 | Host write strobe, one cycle per write |
| hostWrData | input | 8 | Host write data |
| hostRdData | output | 8 | Host read data for hostAddr (combinational) |
| sclk | output | 1 | Shared serial clock, idle high |
| sdo | output | 1 | Serial data to the devices |
| sdi | input | 1 | Serial data from the devices |
| csN | output | NUM_CH | Per-channel active-low selects |

## Verification
A wrong control state shows up at the pins within one half-period. A stray phase flips `sclk` while all selects are high, and a stuck or wrong byte counter changes the count of falling clock edges under the select and the select's low time, which the bench compares against the R7 formula for every transaction. A wrong datapath shift or load shows up as a mismatched serial byte on the next transaction. A capture fault shows up at the next host read through the freeze window. A wrong acceptance decision shows up either as a transaction the scoreboard did not expect or as a changed code at address 3.

// File: rtl/tone_ser_pkg.sv
package tone_ser_pkg;

  typedef enum logic [2:0] {
    CLS_NONE,
    CLS_WR8,
    CLS_WR16,
    CLS_RD8,
    CLS_BAD
  } cmdClass_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_PH0,
    ST_PH1,
    ST_GAP,
    ST_TAIL,
    ST_DONE
  } serState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic accept;    // latch channel, params and command byte
    logic loadByte;  // load next parameter byte into the shifter
    logic byteSel;   // 0: parameter 1, 1: parameter 2
    logic shiftTx;   // advance transmit shifter
    logic shiftRx;   // shift sdi into receive shifter
    logic commit;    // store received byte for latched channel
  } dpStrobe_t;

  localparam logic [3:0] ADDR_CTL  = 4'h0;
  localparam logic [3:0] ADDR_P1   = 4'h1;
  localparam logic [3:0] ADDR_P2   = 4'h2;
  localparam logic [3:0] ADDR_CMD  = 4'h3;
  localparam logic [3:0] ADDR_STAT = 4'hC;
  localparam int FREEZE_BIT = 2;

  function automatic cmdClass_t classify(input logic [7:0] code);
    cmdClass_t c;
    if (code == 8'h01) begin
      c = CLS_NONE;
    end else if (code[7:4] == 4'h8) begin
      case (code[3:2])
        2'b00, 2'b01: c = CLS_WR8;
        2'b10:        c = CLS_WR16;
        default:      c = CLS_RD8;
      endcase
    end else begin
      c = CLS_BAD;
    end
    return c;
  endfunction

  function automatic logic [1:0] paramCount(input cmdClass_t c);
    logic [1:0] n;
    case (c)
      CLS_WR8, CLS_RD8: n = 2'd1;
      CLS_WR16:         n = 2'd2;
      default:          n = 2'd0;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/tone_ser_ctrl.sv
module tone_ser_ctrl
  import tone_ser_pkg::*;
#(
  parameter int HALF_CYC = 200
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic [7:0] startCode,
  input  logic       chanOk,
  output logic       busy,
  output logic       sclk,
  output logic       csActive,
  output logic       txDrive,
  output dpStrobe_t  stb
);

  localparam int DIV_W = $clog2(HALF_CYC + 1);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_CYC - 1);

  serState_t       state;
  cmdClass_t       cls;
  cmdClass_t       startCls;
  logic [DIV_W-1:0] divCnt;
  logic            tickEnd;
  logic            subCnt;
  logic [2:0]      bitIdx;
  logic [1:0]      byteIdx;
  logic            lastByte;
  logic            reading;

  assign startCls = classify(startCode);
  assign tickEnd  = (divCnt == DIV_LAST);
  assign lastByte = (byteIdx == paramCount(cls));
  assign reading  = (cls == CLS_RD8) && (byteIdx == 2'd1);

  assign busy     = (state != ST_IDLE);
  assign csActive = (state == ST_PH0) || (state == ST_PH1) ||
                    (state == ST_GAP) || (state == ST_TAIL);
  assign txDrive  = ((state == ST_PH0) || (state == ST_PH1)) && !reading;

  always_comb begin
    case (state)
      ST_PH0:  sclk = !reading;
      ST_PH1:  sclk = reading;
      default: sclk = 1'b1;
    endcase
  end

  always_comb begin
    stb = '0;
    stb.accept = (state == ST_IDLE) && startReq && (startCls != CLS_BAD) && chanOk;
    if ((state == ST_PH1) && tickEnd) begin
      stb.shiftRx = reading;
      stb.shiftTx = !reading;
      if ((bitIdx == 3'd7) && !lastByte) begin
        stb.loadByte = 1'b1;
        stb.byteSel  = byteIdx[0];
      end
    end
    if (state == ST_DONE) stb.commit = (cls == CLS_RD8);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cls     <= CLS_NONE;
      divCnt  <= '0;
      subCnt  <= 1'b0;
      bitIdx  <= '0;
      byteIdx <= '0;
    end else begin
      if ((state == ST_IDLE) || tickEnd) divCnt <= '0;
      else                               divCnt <= divCnt + 1'b1;
      case (state)
        ST_IDLE: begin
          if (stb.accept) begin
            state   <= ST_PRE;
            cls     <= startCls;
            subCnt  <= 1'b0;
            bitIdx  <= '0;
            byteIdx <= '0;
          end
        end
        ST_PRE: begin
          if (tickEnd) begin
            if (subCnt) begin
              state  <= ST_PH0;
              subCnt <= 1'b0;
            end else begin
              subCnt <= 1'b1;
            end
          end
        end
        ST_PH0: if (tickEnd) state <= ST_PH1;
        ST_PH1: begin
          if (tickEnd) begin
            if (bitIdx == 3'd7) begin
              bitIdx <= '0;
              if (lastByte) begin
                state  <= ST_TAIL;
                subCnt <= 1'b0;
              end else begin
                byteIdx <= byteIdx + 1'b1;
                state   <= ST_GAP;
              end
            end else begin
              bitIdx <= bitIdx + 1'b1;
              state  <= ST_PH0;
            end
          end
        end
        ST_GAP: if (tickEnd) state <= ST_PH0;
        ST_TAIL: begin
          if (tickEnd) begin
            if (subCnt) state <= ST_DONE;
            else        subCnt <= 1'b1;
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/tone_ser_dp.sv
module tone_ser_dp
  import tone_ser_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        hostAddr,
  input  logic              hostWr,
  input  logic [7:0]        hostWrData,
  output logic [7:0]        hostRdData,
  input  dpStrobe_t         stb,
  input  logic              csActive,
  input  logic              txDrive,
  input  logic              busy,
  input  logic              sdi,
  output logic              sdo,
  output logic [NUM_CH-1:0] csN,
  output logic              chanOk
);

  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam logic [6:0] CH_LIMIT   = 7'(NUM_CH);
  localparam logic [3:0] VIEW_LIMIT = 4'(NUM_CH);

  logic [7:0]      regCtl, regP1, regP2, regCmd;
  logic [7:0]      p1Lat, p2Lat;
  logic [7:0]      txShift, rxShift;
  logic [CH_W-1:0] chanLat;
  logic [6:0]      chanFull;
  logic            freeze;
  logic [7:0]      statusLive [NUM_CH];
  logic [7:0]      statusView [NUM_CH];

  assign chanFull = {regCtl[7:3], regCtl[1:0]};
  assign chanOk   = (chanFull < CH_LIMIT);
  assign freeze   = regCtl[FREEZE_BIT];
  assign sdo      = txDrive ? txShift[7] : 1'b1;

  // host configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regCtl <= '0;
      regP1  <= '0;
      regP2  <= '0;
      regCmd <= '0;
    end else begin
      if (hostWr) begin
        case (hostAddr)
          ADDR_CTL: regCtl <= hostWrData;
          ADDR_P1:  regP1  <= hostWrData;
          ADDR_P2:  regP2  <= hostWrData;
          default: ;
        endcase
      end
      if (stb.accept) regCmd <= hostWrData;
    end
  end

  // transaction latches and shifters
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chanLat <= '0;
      p1Lat   <= '0;
      p2Lat   <= '0;
      txShift <= 8'hFF;
      rxShift <= '0;
    end else begin
      if (stb.accept) begin
        chanLat <= chanFull[CH_W-1:0];
        p1Lat   <= regP1;
        p2Lat   <= regP2;
        txShift <= hostWrData;
      end else if (stb.loadByte) begin
        txShift <= stb.byteSel ? p2Lat : p1Lat;
      end else if (stb.shiftTx) begin
        txShift <= {txShift[6:0], 1'b1};
      end
      if (stb.shiftRx) rxShift <= {rxShift[6:0], sdi};
    end
  end

  // per-channel status store and freeze snapshot
  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          statusLive[g] <= '0;
          statusView[g] <= '0;
        end else begin
          if (stb.commit && (chanLat == CH_W'(g))) statusLive[g] <= rxShift;
          if (!freeze) statusView[g] <= statusLive[g];
        end
      end
      assign csN[g] = !(csActive && (chanLat == CH_W'(g)));
    end
  endgenerate

  always_comb begin
    hostRdData = '0;
    if (hostAddr == ADDR_STAT) begin
      hostRdData = {7'b0, busy};
    end else if (freeze && (hostAddr < VIEW_LIMIT)) begin
      hostRdData = statusView[hostAddr[CH_W-1:0]];
    end else begin
      case (hostAddr)
        ADDR_CTL: hostRdData = regCtl;
        ADDR_P1:  hostRdData = regP1;
        ADDR_P2:  hostRdData = regP2;
        ADDR_CMD: hostRdData = regCmd;
        default:  hostRdData = '0;
      endcase
    end
  end

endmodule

// File: rtl/tone_ser_master.sv
module tone_ser_master
  import tone_ser_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int HALF_CYC = 200
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        hostAddr,
  input  logic              hostWr,
  input  logic [7:0]        hostWrData,
  output logic [7:0]        hostRdData,
  output logic              sclk,
  output logic              sdo,
  input  logic              sdi,
  output logic [NUM_CH-1:0] csN
);

  dpStrobe_t stb;
  logic      busy, csActive, txDrive, chanOk, startReq;

  assign startReq = hostWr && (hostAddr == ADDR_CMD);

  tone_ser_ctrl #(.HALF_CYC(HALF_CYC)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startReq  (startReq),
    .startCode (hostWrData),
    .chanOk    (chanOk),
    .busy      (busy),
    .sclk      (sclk),
    .csActive  (csActive),
    .txDrive   (txDrive),
    .stb       (stb)
  );

  tone_ser_dp #(.NUM_CH(NUM_CH)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .hostAddr   (hostAddr),
    .hostWr     (hostWr),
    .hostWrData (hostWrData),
    .hostRdData (hostRdData),
    .stb        (stb),
    .csActive   (csActive),
    .txDrive    (txDrive),
    .busy       (busy),
    .sdi        (sdi),
    .sdo        (sdo),
    .csN        (csN),
    .chanOk     (chanOk)
  );

endmodule

// File: rtl/tone_ser_checker.sv
module tone_ser_checker #(
  parameter int NUM_CH = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [3:0]        hostAddr,
  input logic              hostWr,
  input logic              sclk,
  input logic              sdo,
  input logic [NUM_CH-1:0] csN,
  input logic              busy
);

  assert_onehot_cs_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~csN));

  assert_idle_cs_R1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (&csN));

  assert_idle_lines_R4: assert property (@(posedge clk) disable iff (!rstN)
    (&csN) |-> (sclk && sdo));

  assert_pre_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(&csN) |-> ($past(sdo) && $past(sclk)));

  assert_cs_steady_R12: assert property (@(posedge clk) disable iff (!rstN)
    (!(&csN) && !(&$past(csN))) |-> (csN == $past(csN)));

  assert_busy_start_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(hostWr && (hostAddr == 4'h3)));

endmodule

bind tone_ser_master tone_ser_checker #(.NUM_CH(NUM_CH)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .hostAddr (hostAddr),
  .hostWr   (hostWr),
  .sclk     (sclk),
  .sdo      (sdo),
  .csN      (csN),
  .busy     (u_ctrl.busy)
);

// File: tb/tb_tone_ser_master.sv
`timescale 1ns/1ps
module tb_tone_ser_master;

  localparam int NCH  = 4;
  localparam int HALF = 4;
  localparam int PER  = 5;

  typedef struct {
    int          ch;
    int          nbits;
    logic [31:0] bits;
    int          cycles;
    string       tag;
  } expItem_t;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [3:0]      hostAddr = '0;
  logic            hostWr = 1'b0;
  logic [7:0]      hostWrData = '0;
  logic [7:0]      hostRdData;
  logic            sclk, sdo;
  logic            sdi = 1'b1;
  logic [NCH-1:0]  csN;

  int checks = 0;
  int failures = 0;
  expItem_t expQ[$];
  logic [7:0] devResp = 8'h00;

  always #(PER/2.0) clk = ~clk;

  tone_ser_master #(.NUM_CH(NCH), .HALF_CYC(HALF)) dut (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWr(hostWr),
    .hostWrData(hostWrData), .hostRdData(hostRdData), .sclk(sclk),
    .sdo(sdo), .sdi(sdi), .csN(csN)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- monitor (scoreboard consumer) ----------------
  logic        csAll;
  logic        monActive = 1'b0;
  int          monCh, monN, fallCnt;
  logic [31:0] monBits;
  time         t0;
  assign csAll = &csN;

  always @(negedge csAll) begin
    monActive = 1'b1;
    t0 = $time;
    monN = 0;
    monBits = '0;
    fallCnt = 0;
    monCh = -1;
    for (int i = 0; i < NCH; i++) if (!csN[i]) monCh = i;
    #1;
    check(sclk === 1'b1, "R4", "sclk high at select", sclk, 1);
  end

  always @(negedge sclk) begin
    if (monActive) begin
      monBits = {monBits[30:0], sdo};
      monN++;
      fallCnt++;
      if (fallCnt >= 9 && fallCnt <= 16) sdi = devResp[16 - fallCnt];
    end
  end

  always @(posedge csAll) begin
    if (monActive) begin
      expItem_t e;
      int cyc;
      monActive = 1'b0;
      sdi = 1'b1;
      cyc = int'(($time - t0) / PER);
      if (expQ.size() == 0) begin
        check(1'b0, "R11", "unexpected transaction on channel", monCh, -1);
      end else begin
        e = expQ.pop_front();
        check(monCh == e.ch, "R1", {e.tag, " channel"}, monCh, e.ch);
        check(monN == e.nbits, "R3", {e.tag, " bit count"}, monN, e.nbits);
        check(monBits == e.bits, "R5", {e.tag, " serial bits"}, monBits, e.bits);
        check(cyc == e.cycles, "R7", {e.tag, " select low time"}, cyc, e.cycles);
      end
    end
  end

  // ---------------- driver ----------------
  task automatic hostWrite(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    hostAddr = a; hostWrData = d; hostWr = 1'b1;
    @(negedge clk);
    hostWr = 1'b0;
  endtask

  task automatic hostRead(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    hostAddr = a;
    #1;
    d = hostRdData;
  endtask

  task automatic waitIdle();
    logic [7:0] b;
    for (int i = 0; i < 4000; i++) begin
      hostRead(4'hC, b);
      if (b[0] == 1'b0) break;
    end
  endtask

  // expected shape of a command from the R3 table; -1 when invalid
  function automatic int benchParams(input logic [7:0] c, output bit rd);
    rd = 1'b0;
    if (c == 8'h01) return 0;
    if (c >= 8'h80 && c <= 8'h87) return 1;
    if (c >= 8'h88 && c <= 8'h8B) return 2;
    if (c >= 8'h8C && c <= 8'h8F) begin rd = 1'b1; return 1; end
    return -1;
  endfunction

  task automatic startCmd(input logic [7:0] ctl, input logic [7:0] code,
                          input logic [7:0] p1, input logic [7:0] p2,
                          input logic [7:0] resp, input string tag);
    expItem_t e;
    bit rd;
    int np;
    int ch;
    np = benchParams(code, rd);
    ch = {ctl[7:3], ctl[1:0]};
    hostWrite(4'h1, p1);
    hostWrite(4'h2, p2);
    hostWrite(4'h0, ctl);
    devResp = resp;
    if (np >= 0 && ch < NCH) begin
      e.ch = ch;
      e.nbits = 8 * (np + 1);
      if (np == 0)      e.bits = {24'h0, code};
      else if (rd)      e.bits = {16'h0, code, 8'hFF};
      else if (np == 1) e.bits = {16'h0, code, p1};
      else              e.bits = {8'h0, code, p1, p2};
      e.cycles = HALF * (16 * (np + 1) + np + 2);
      e.tag = tag;
      expQ.push_back(e);
    end
    hostWrite(4'h3, code);
  endtask

  task automatic runCmd(input logic [7:0] ctl, input logic [7:0] code,
                        input logic [7:0] p1, input logic [7:0] p2,
                        input logic [7:0] resp, input string tag);
    startCmd(ctl, code, p1, p2, resp, tag);
    waitIdle();
    repeat (3) @(negedge clk);
  endtask

  bit watchdogHit = 1'b0;
  initial begin
    #(PER * 150000);
    watchdogHit = 1'b1;
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    // reset state
    check(csN == '1, "R1", "selects after reset", csN, 4'hF);
    check(sclk === 1'b1 && sdo === 1'b1, "R4", "idle lines after reset", {sclk, sdo}, 2'b11);
    rstN = 1'b1;
    hostRead(4'hC, r);
    check(r == 8'h00, "R8", "busy after reset", r, 0);

    // register readback with freeze clear
    hostWrite(4'h1, 8'h5A);
    hostRead(4'h1, r);
    check(r == 8'h5A, "R8", "param1 readback", r, 8'h5A);

    // busy visible the cycle after start
    startCmd(8'h00, 8'h83, 8'hC3, 8'h00, 8'h00, "wr8 ch0");
    hostRead(4'hC, r);
    check(r[0] == 1'b1, "R8", "busy after start", r, 1);
    waitIdle();
    repeat (3) @(negedge clk);

    runCmd(8'h01, 8'h01, 8'hFF, 8'hFF, 8'h00, "reset cmd ch1 R12");
    runCmd(8'h02, 8'h89, 8'h12, 8'hED, 8'h00, "wr16 ch2");
    runCmd(8'h03, 8'h80, 8'h00, 8'h00, 8'h00, "wr8 zero ch3");

    // read on channel 2
    runCmd(8'h02, 8'h8C, 8'h00, 8'h00, 8'hA5, "rd8 ch2 R6");
    hostRead(4'h2, r);
    check(r == 8'h00, "R10", "unfrozen addr2 shows param2", r, 8'h00);
    hostWrite(4'h0, 8'h06);
    hostRead(4'h2, r);
    check(r == 8'hA5, "R6", "captured read byte ch2", r, 8'hA5);
    // read again while frozen: snapshot unchanged
    runCmd(8'h06, 8'h8F, 8'h00, 8'h00, 8'h3C, "rd8 ch2 frozen");
    hostRead(4'h2, r);
    check(r == 8'hA5, "R10", "snapshot held while frozen", r, 8'hA5);
    hostRead(4'h1, r);
    check(r == 8'h00, "R10", "other channel snapshot", r, 8'h00);
    hostWrite(4'h0, 8'h02);
    hostWrite(4'h0, 8'h06);
    hostRead(4'h2, r);
    check(r == 8'h3C, "R10", "snapshot after thaw", r, 8'h3C);
    hostWrite(4'h0, 8'h00);
    hostRead(4'h3, r);
    check(r == 8'h8F, "R8", "last code readback", r, 8'h8F);

    // command write while busy is dropped
    startCmd(8'h03, 8'h8A, 8'h77, 8'h88, 8'h00, "wr16 ch3 busy test");
    repeat (10) @(negedge clk);
    hostWrite(4'h3, 8'h81);
    waitIdle();
    repeat (3) @(negedge clk);
    hostRead(4'h3, r);
    check(r == 8'h8A, "R9", "code after dropped write", r, 8'h8A);

    // unknown code
    startCmd(8'h01, 8'h55, 8'h00, 8'h00, 8'h00, "bad code");
    hostRead(4'hC, r);
    check(r[0] == 1'b0, "R11", "busy for unknown code", r, 0);
    repeat (40) @(negedge clk);
    hostRead(4'h3, r);
    check(r == 8'h8A, "R11", "code unchanged by unknown", r, 8'h8A);

    // channel out of range
    startCmd(8'h08, 8'h84, 8'h00, 8'h00, 8'h00, "chan 4");
    hostRead(4'hC, r);
    check(r[0] == 1'b0, "R2", "busy for channel 4", r, 0);
    repeat (40) @(negedge clk);
    check(csN == '1, "R2", "no select for channel 4", csN, 4'hF);

    repeat (5) @(negedge clk);
    check(expQ.size() == 0, "R3", "all expected transactions seen", expQ.size(), 0);
    if (!watchdogHit) begin
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule